// File: doc/BRIEF.md
# Speculative Fault Deferral Register File

This block is a register file in which every entry carries a poison flag beside its data. It lets a compiler hoist loads and other instructions above the branch that guards them. Each issued instruction is marked as either speculative or ordinary. A fatal fault raised by a speculative instruction does not trap. The instruction instead marks its destination as poisoned, and the poison then travels with the value. An ordinary instruction that consumes a poisoned operand turns the deferred fault into a trap. A sentinel check left at the instruction's original program position asks for recovery when the register it tests is poisoned.

A fault that can be resumed, such as a missing page, is reported at once for service whether or not the instruction is speculative. Servicing it costs only time. Reads are combinational and return the data together with its poison flag. Trap, recovery and service requests are registered pulses that appear in the cycle after the instruction issues. One instruction issues per clock, and the block performs at most one register write per clock.

Top module: `defer_poison_rf`

## Requirements
- R1: After synchronous reset, every entry reads data zero with its poison flag clear, and trap_o, recover_o and svc_o are low.
- R2: An ordinary or speculative instruction (iss_check=0) with unpoisoned sources and iss_fault=2'b00 writes iss_result to iss_dst and clears that entry's poison flag.
- R3: A speculative instruction with unpoisoned sources and a fatal fault (iss_fault bit 1 set, codes 2'b10 and 2'b11) sets the poison flag of iss_dst, writes data zero and raises no trap.
- R4: An instruction with unpoisoned sources and iss_fault=2'b01 (resumable) pulses svc_o for one cycle, whether speculative or not, and leaves iss_dst unchanged.
- R5: An ordinary instruction (iss_spec=0) that reads a poisoned source pulses trap_o with trap_cause=0 and trap_reg set to the poisoned source; src A is reported when both are poisoned. iss_dst is left unchanged.
- R6: An ordinary instruction with unpoisoned sources and a fatal fault pulses trap_o with trap_cause=1 and trap_reg=iss_dst, and leaves iss_dst unchanged.
- R7: A speculative instruction that reads a poisoned source poisons iss_dst, writes data zero and raises no trap and no service request, whatever its fault code.
- R8: A sentinel check (iss_check=1) tests the entry named by iss_src_a. If that entry is poisoned, recover_o pulses with recover_reg equal to that index. A check never writes any register.
- R9: The trap, recovery and service outputs go high in the cycle after the issuing clock edge and last one cycle per instruction. At most one of them is high in any cycle.
- R10: When iss_valid is low, no register changes and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_check | input | 1 | 1 = sentinel check of src A, 0 = executing instruction |
| iss_spec | input | 1 | 1 = speculative instruction |
| iss_src_a | input | IW | Source A index, also the read port A address |
| iss_src_b | input | IW | Source B index, also the read port B address |
| iss_dst | input | IW | Destination index |
| iss_fault | input | 2 | 00 none, 01 resumable, 1x fatal |
| iss_result | input | DW | Result data to write |
| rd_a_data | output | DW | Data of entry iss_src_a |
| rd_a_nat | output | 1 | Poison flag of entry iss_src_a |
| rd_b_data | output | DW | Data of entry iss_src_b |
| rd_b_nat | output | 1 | Poison flag of entry iss_src_b |
| trap_o | output | 1 | Terminating trap request pulse |
| trap_reg | output | IW | Register index behind the trap |
| trap_cause | output | 1 | 0 = poisoned operand consumed, 1 = direct fatal fault |
| recover_o | output | 1 | Recovery request pulse from a sentinel |
| recover_reg | output | IW | Entry the sentinel found poisoned |
| svc_o | output | 1 | Resumable fault service request pulse |

## Verification
A poison flag that is lost or set in error stays invisible until a later instruction reads the entry. At that point it shows as a missing or spurious trap, recovery or propagated poison, one cycle after that reader issues, or as a wrong flag on the combinational read port. For that reason, the bench reads the destination back after every instruction and also scans the whole file at intervals. A write made in the wrong case corrupts a value that an earlier check saw as correct. The read-back right after the write exposes it within one cycle.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

    // Fault class carried with each issued instruction
    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_RESUME = 2'b01,
        FLT_FATAL  = 2'b10,
        FLT_FATAL2 = 2'b11
    } fault_e;

    // Outcome chosen for one issued instruction
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_WRITE,
        ACT_POISON,
        ACT_TRAP_NAT,
        ACT_TRAP_FLT,
        ACT_RECOVER,
        ACT_SERVICE
    } act_e;

    function automatic logic fault_is_fatal(input fault_e f);
        return f[1];
    endfunction

    function automatic logic act_writes(input act_e a);
        return (a == ACT_WRITE) || (a == ACT_POISON);
    endfunction

    function automatic logic act_traps(input act_e a);
        return (a == ACT_TRAP_NAT) || (a == ACT_TRAP_FLT);
    endfunction

endpackage

// File: rtl/dpr_regfile.sv
`timescale 1ns/1ps
module dpr_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          wnat,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr_a,
    input  logic [IW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic          rnat_a,
    output logic [DW-1:0] rdata_b,
    output logic          rnat_b
);
    logic [DW-1:0] data_q [NREG];
    logic          nat_q  [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[g] <= '0;
                nat_q[g]  <= 1'b0;
            end else if (we && (waddr == IW'(g))) begin
                data_q[g] <= wdata;
                nat_q[g]  <= wnat;
            end
        end
    end

    always_comb begin
        rdata_a = data_q[raddr_a];
        rnat_a  = nat_q[raddr_a];
        rdata_b = data_q[raddr_b];
        rnat_b  = nat_q[raddr_b];
    end
endmodule

// File: rtl/dpr_decide.sv
`timescale 1ns/1ps
module dpr_decide
    import dpr_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          valid,
    input  logic          check,
    input  logic          spec,
    input  logic [IW-1:0] src_a,
    input  logic [IW-1:0] src_b,
    input  logic [IW-1:0] dst,
    input  fault_e        fault,
    input  logic          nat_a,
    input  logic          nat_b,
    output act_e          act,
    output logic [IW-1:0] ev_reg
);
    // Poisoned operands take precedence over the instruction's own fault:
    // a speculative consumer just forwards the poison.
    always_comb begin
        act    = ACT_NONE;
        ev_reg = '0;
        if (valid) begin
            if (check) begin
                if (nat_a) begin
                    act    = ACT_RECOVER;
                    ev_reg = src_a;
                end
            end else if (nat_a || nat_b) begin
                if (spec) begin
                    act = ACT_POISON;
                end else begin
                    act    = ACT_TRAP_NAT;
                    ev_reg = nat_a ? src_a : src_b;
                end
            end else if (fault == FLT_RESUME) begin
                act = ACT_SERVICE;
            end else if (fault_is_fatal(fault)) begin
                if (spec) begin
                    act = ACT_POISON;
                end else begin
                    act    = ACT_TRAP_FLT;
                    ev_reg = dst;
                end
            end else begin
                act = ACT_WRITE;
            end
        end
    end
endmodule

// File: rtl/dpr_event.sv
`timescale 1ns/1ps
module dpr_event
    import dpr_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  act_e          act,
    input  logic [IW-1:0] ev_reg,
    output logic          trap_o,
    output logic [IW-1:0] trap_reg,
    output logic          trap_cause,
    output logic          recover_o,
    output logic [IW-1:0] recover_reg,
    output logic          svc_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            trap_o      <= 1'b0;
            trap_reg    <= '0;
            trap_cause  <= 1'b0;
            recover_o   <= 1'b0;
            recover_reg <= '0;
            svc_o       <= 1'b0;
        end else begin
            trap_o      <= act_traps(act);
            trap_reg    <= act_traps(act) ? ev_reg : '0;
            trap_cause  <= (act == ACT_TRAP_FLT);
            recover_o   <= (act == ACT_RECOVER);
            recover_reg <= (act == ACT_RECOVER) ? ev_reg : '0;
            svc_o       <= (act == ACT_SERVICE);
        end
    end
endmodule

// File: rtl/defer_poison_rf.sv
`timescale 1ns/1ps
module defer_poison_rf
    import dpr_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iss_valid,
    input  logic          iss_check,
    input  logic          iss_spec,
    input  logic [IW-1:0] iss_src_a,
    input  logic [IW-1:0] iss_src_b,
    input  logic [IW-1:0] iss_dst,
    input  logic [1:0]    iss_fault,
    input  logic [DW-1:0] iss_result,
    output logic [DW-1:0] rd_a_data,
    output logic          rd_a_nat,
    output logic [DW-1:0] rd_b_data,
    output logic          rd_b_nat,
    output logic          trap_o,
    output logic [IW-1:0] trap_reg,
    output logic          trap_cause,
    output logic          recover_o,
    output logic [IW-1:0] recover_reg,
    output logic          svc_o
);
    act_e          act;
    logic [IW-1:0] ev_reg;
    logic          wr_en;
    logic          wr_nat;
    logic [DW-1:0] wr_data;

    dpr_regfile #(.NREG(NREG), .DW(DW)) i_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .wnat    (wr_nat),
        .waddr   (iss_dst),
        .wdata   (wr_data),
        .raddr_a (iss_src_a),
        .raddr_b (iss_src_b),
        .rdata_a (rd_a_data),
        .rnat_a  (rd_a_nat),
        .rdata_b (rd_b_data),
        .rnat_b  (rd_b_nat)
    );

    dpr_decide #(.IW(IW)) i_dec (
        .valid  (iss_valid),
        .check  (iss_check),
        .spec   (iss_spec),
        .src_a  (iss_src_a),
        .src_b  (iss_src_b),
        .dst    (iss_dst),
        .fault  (fault_e'(iss_fault)),
        .nat_a  (rd_a_nat),
        .nat_b  (rd_b_nat),
        .act    (act),
        .ev_reg (ev_reg)
    );

    always_comb begin
        wr_en   = act_writes(act);
        wr_nat  = (act == ACT_POISON);
        wr_data = (act == ACT_WRITE) ? iss_result : '0;
    end

    dpr_event #(.IW(IW)) i_evt (
        .clk         (clk),
        .rst         (rst),
        .act         (act),
        .ev_reg      (ev_reg),
        .trap_o      (trap_o),
        .trap_reg    (trap_reg),
        .trap_cause  (trap_cause),
        .recover_o   (recover_o),
        .recover_reg (recover_reg),
        .svc_o       (svc_o)
    );
endmodule

// File: rtl/dpr_checker.sv
`timescale 1ns/1ps
module dpr_checker (
    input logic clk,
    input logic rst,
    input logic iss_valid,
    input logic iss_check,
    input logic iss_spec,
    input logic rd_a_nat,
    input logic wr_en,
    input logic trap_o,
    input logic recover_o,
    input logic svc_o
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!trap_o && !recover_o && !svc_o));

    p_one_event_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trap_o, recover_o, svc_o}));

    p_event_after_issue_r9: assert property (@(posedge clk) disable iff (rst)
        (trap_o || recover_o || svc_o) |-> $past(iss_valid));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |=> (!trap_o && !recover_o && !svc_o));

    p_idle_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> !wr_en);

    p_check_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_check) |-> !wr_en);

    p_recover_needs_nat_r8: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_check && rd_a_nat) |=> recover_o);

    p_spec_no_trap_r3: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_check && iss_spec) |=> !trap_o);
endmodule

bind defer_poison_rf dpr_checker i_dpr_checker (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_check (iss_check),
    .iss_spec  (iss_spec),
    .rd_a_nat  (rd_a_nat),
    .wr_en     (wr_en),
    .trap_o    (trap_o),
    .recover_o (recover_o),
    .svc_o     (svc_o)
);

// File: tb/test_defer_poison_rf.sv
`timescale 1ns/1ps
module test_defer_poison_rf;
    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int IW   = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst;
    logic          iss_valid, iss_check, iss_spec;
    logic [IW-1:0] iss_src_a, iss_src_b, iss_dst;
    logic [1:0]    iss_fault;
    logic [DW-1:0] iss_result;
    logic [DW-1:0] rd_a_data, rd_b_data;
    logic          rd_a_nat, rd_b_nat;
    logic          trap_o, trap_cause, recover_o, svc_o;
    logic [IW-1:0] trap_reg, recover_reg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] m_data [NREG];
    logic          m_nat  [NREG];

    always #4 clk = ~clk;

    defer_poison_rf #(.NREG(NREG), .DW(DW)) i_defer_poison_rf (.*);

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_reg(input logic [IW-1:0] idx, input string req);
        iss_valid = 1'b0;
        iss_src_a = idx;
        iss_src_b = idx;
        #1;
        check(req, $sformatf("data r%0d", idx), 64'(rd_a_data), 64'(m_data[idx]));
        check(req, $sformatf("nat r%0d", idx), 64'(rd_a_nat), 64'(m_nat[idx]));
    endtask

    task automatic check_events(input string req, input int ev,
                                input logic [IW-1:0] er, input logic ec);
        check(req, "trap/recover/svc", 64'({trap_o, recover_o, svc_o}),
              64'({ev == 1, ev == 2, ev == 3}));
        check(req, "trap_reg", 64'(trap_reg), (ev == 1) ? 64'(er) : 64'd0);
        check(req, "trap_cause", 64'(trap_cause), 64'(ev == 1 && ec));
        check(req, "recover_reg", 64'(recover_reg), (ev == 2) ? 64'(er) : 64'd0);
    endtask

    // ev: 0 none, 1 trap, 2 recover, 3 service
    task automatic issue(input logic chk, input logic spec,
                         input logic [IW-1:0] a, input logic [IW-1:0] b,
                         input logic [IW-1:0] d, input logic [1:0] f,
                         input logic [DW-1:0] v);
        int ev = 0;
        logic [IW-1:0] er = '0;
        logic ec = 1'b0;
        string req;
        if (chk) begin
            req = "R8";
            if (m_nat[a]) begin ev = 2; er = a; end
        end else if (m_nat[a] || m_nat[b]) begin
            if (spec) begin
                req = "R7"; m_nat[d] = 1'b1; m_data[d] = '0;
            end else begin
                req = "R5"; ev = 1; er = m_nat[a] ? a : b;
            end
        end else if (f == 2'b01) begin
            req = "R4"; ev = 3;
        end else if (f[1]) begin
            if (spec) begin
                req = "R3"; m_nat[d] = 1'b1; m_data[d] = '0;
            end else begin
                req = "R6"; ev = 1; er = d; ec = 1'b1;
            end
        end else begin
            req = "R2"; m_nat[d] = 1'b0; m_data[d] = v;
        end
        @(negedge clk);
        iss_valid = 1'b1; iss_check = chk; iss_spec = spec;
        iss_src_a = a; iss_src_b = b; iss_dst = d;
        iss_fault = f; iss_result = v;
        @(negedge clk);
        check_events(req, ev, er, ec);
        check_reg(d, req);
    endtask

    task automatic idle_cycle(input string req);
        @(negedge clk);
        iss_valid = 1'b0; iss_check = 1'b0; iss_spec = 1'b0;
        iss_fault = 2'b10; iss_dst = 4'd1; iss_result = 32'hDEAD_BEEF;
        @(negedge clk);
        check_events(req, 0, '0, 1'b0);
    endtask

    task automatic scan_all(input string req);
        for (int i = 0; i < NREG; i++) check_reg(IW'(i), req);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NREG; i++) begin m_data[i] = '0; m_nat[i] = 1'b0; end
        rst = 1'b1; iss_valid = 1'b0; iss_check = 1'b0; iss_spec = 1'b0;
        iss_src_a = '0; iss_src_b = '0; iss_dst = '0; iss_fault = '0; iss_result = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_events("R1", 0, '0, 1'b0);
        scan_all("R1");

        // Directed corner cases
        issue(0, 0, 4'd0, 4'd0, 4'd1, 2'b00, 32'h0000_0005); // R2 write
        issue(0, 1, 4'd1, 4'd0, 4'd2, 2'b10, 32'h1234_5678); // R3 spec fatal
        issue(0, 1, 4'd0, 4'd1, 4'd9, 2'b11, 32'h0BAD_0BAD); // R3 alt fatal code
        issue(1, 0, 4'd2, 4'd0, 4'd1, 2'b00, 32'hFFFF_FFFF); // R8 poisoned check
        issue(1, 0, 4'd1, 4'd2, 4'd1, 2'b00, 32'hFFFF_FFFF); // R8 clean check
        issue(0, 0, 4'd2, 4'd1, 4'd3, 2'b00, 32'hAAAA_AAAA); // R5 src A poisoned
        idle_cycle("R9");                                    // pulse ends
        issue(0, 0, 4'd1, 4'd9, 4'd3, 2'b00, 32'hAAAA_AAAA); // R5 src B poisoned
        issue(0, 0, 4'd9, 4'd2, 4'd3, 2'b00, 32'hAAAA_AAAA); // R5 both: A wins
        issue(0, 1, 4'd1, 4'd2, 4'd4, 2'b01, 32'h5555_5555); // R7 no service
        issue(0, 1, 4'd4, 4'd4, 4'd5, 2'b10, 32'h5555_5555); // R7 chain
        issue(0, 0, 4'd1, 4'd1, 4'd6, 2'b01, 32'h7777_7777); // R4 non-spec
        issue(0, 1, 4'd1, 4'd1, 4'd1, 2'b01, 32'h7777_7777); // R4 spec
        issue(0, 0, 4'd1, 4'd0, 4'd7, 2'b10, 32'h8888_8888); // R6 fatal
        issue(0, 0, 4'd0, 4'd1, 4'd2, 2'b00, 32'hCAFE_F00D); // R2 clears nat
        issue(0, 0, 4'd2, 4'd2, 4'd2, 2'b00, 32'h0000_0000); // R2 self
        idle_cycle("R10");
        scan_all("R10");

        // Constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            logic chk = ($urandom_range(0, 5) == 0);
            logic spec = $urandom_range(0, 1);
            int fr = $urandom_range(0, 9);
            logic [1:0] f = (fr < 5) ? 2'b00 : (fr < 7) ? 2'b01 : (fr < 9) ? 2'b10 : 2'b11;
            if ($urandom_range(0, 15) == 0) idle_cycle("R10");
            issue(chk, spec, IW'($urandom_range(0, NREG - 1)), IW'($urandom_range(0, NREG - 1)),
                  IW'($urandom_range(0, NREG - 1)), f, $urandom);
            if (n % 100 == 99) scan_all("R2");
        end
        scan_all("R2");
        done = 1;
        finish_run();
    end
endmodule